// File: doc/BRIEF.md
# AHB Slave Response Compliance Monitor

This block sits passively beside one AHB slave port and watches only the selection, transfer-type, ready and response wires. Every clock it places the port into one state of a small protocol state machine: unselected, in the data phase of an IDLE or BUSY transfer, in the data phase of an active transfer, stretched by wait cycles, or halfway through a two-cycle ERROR response. A response the slave is not allowed to give sends the machine into a dedicated fault state. That state is absorbing.

The fault is found by walking this one state machine. It is not spread over many independent signal checks, so each fault can be traced to the state the port was in and the response seen there. Reading versus writing, burst type, addresses and data have no effect on the machine. The current state, a sticky fault flag and a single-cycle fault pulse are all registered outputs. Each one changes on the clock edge that samples the offending cycle.

Top module: `ahb_resp_monitor`

## Requirements
- R1: While reset is low, and in the first cycle after it, the state output is 0 (unselected), and the sticky and pulse outputs are 0. State codes: 0 unselected, 1 IDLE/BUSY data phase, 2 active data phase, 3 waiting, 4 first ERROR cycle seen, 5 fault.
- R2: When no data phase is pending (state 0), or a data phase completes legally, the next state comes from the address inputs. Select low gives 0. Transfer type IDLE (2'b00) or BUSY (2'b01) gives 1. NONSEQ (2'b10) or SEQ (2'b11) gives 2.
- R3: In state 1, a cycle with ready low, or with a response other than OKAY (2'b00), moves the machine to state 5.
- R4: In state 2 or 3, ready low with an OKAY response moves the machine to state 3, and it stays in state 3 while that holds.
- R5: In state 2 or 3, ready high with the ERROR response (2'b01) moves the machine to state 5. A stretched transfer may only finish with OKAY, and an ERROR needs a preceding low-ready cycle.
- R6: In state 2 or 3, ready low with the ERROR response moves the machine to state 4.
- R7: In state 4, only ready high with the ERROR response is legal, and it completes the data phase as in R2. Any other cycle moves the machine to state 5.
- R8: State 5 holds until reset, whatever the inputs do. The sticky output is 1 exactly while the state is 5.
- R9: The pulse output is 1 for exactly the one cycle in which the state first shows 5.
- R10: The response codes 2'b10 and 2'b11 are violations wherever a response is checked (states 1 to 4).
- R11: In state 0, the ready and response inputs have no effect on the next state.
- R12: While a data phase is stretched (state 2 or 3 with ready low), the select and transfer-type inputs have no effect on the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Slave select seen on the bus |
| trans_i | input | 2 | Transfer type of the current address phase |
| ready_i | input | 1 | Ready driven by the slave |
| resp_i | input | 2 | Response driven by the slave |
| state_o | output | 3 | Current protocol state (codes in R1) |
| fault_sticky_o | output | 1 | Set when the fault state is entered; cleared only by reset |
| fault_pulse_o | output | 1 | One-cycle marker of fault entry |

## Verification
Every output is a flop. A bus cycle driven before a rising edge therefore shows its effect on the state, sticky and pulse outputs right after that edge: a latency of one cycle for all three. The bench drives each cycle on the falling edge and lets one rising edge pass. At the next falling edge it compares all three outputs with a behavioural reference that has already been advanced by the same cycle. The pulse is checked both in its entry cycle and in the cycle after it, which is where a stretched pulse would show.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;

    localparam int TRANS_W = 2;
    localparam int RESP_W  = 2;
    localparam int STATE_W = 3;

    localparam logic [TRANS_W-1:0] HT_IDLE   = 2'b00;
    localparam logic [TRANS_W-1:0] HT_BUSY   = 2'b01;
    localparam logic [TRANS_W-1:0] HT_NONSEQ = 2'b10;
    localparam logic [TRANS_W-1:0] HT_SEQ    = 2'b11;

    localparam logic [RESP_W-1:0] RSP_OKAY  = 2'b00;
    localparam logic [RESP_W-1:0] RSP_ERROR = 2'b01;

    typedef enum logic [STATE_W-1:0] {
        SP_ORIG     = 3'd0,
        SP_IDLEBUSY = 3'd1,
        SP_XFER     = 3'd2,
        SP_WAIT     = 3'd3,
        SP_ERRRSP   = 3'd4,
        SP_FAULT    = 3'd5
    } spec_state_e;

    // What the response seen in the current cycle means for the pending data phase
    typedef enum logic [2:0] {
        JV_NONE,      // no data phase pending
        JV_DONE,      // data phase finished legally
        JV_STRETCH,   // legal wait cycle
        JV_ERR_FIRST, // legal first cycle of an ERROR response
        JV_VIOL       // illegal response
    } verdict_e;

    typedef struct packed {
        spec_state_e st;
        logic        sticky;
        logic        pulse;
    } mon_regs_t;

endpackage

// File: rtl/ahb_mon_phase_judge.sv
module ahb_mon_phase_judge
    import ahb_mon_pkg::*;
(
    input  spec_state_e             st_i,
    input  logic                    ready_i,
    input  logic [RESP_W-1:0]       resp_i,
    output verdict_e                verdict_o
);

    logic is_okay;
    logic is_error;

    assign is_okay  = (resp_i == RSP_OKAY);
    assign is_error = (resp_i == RSP_ERROR);

    always_comb begin
        verdict_o = JV_VIOL;
        unique case (st_i)
            SP_ORIG: begin
                verdict_o = JV_NONE;
            end
            SP_IDLEBUSY: begin
                // zero-wait OKAY is the only legal answer
                verdict_o = (ready_i && is_okay) ? JV_DONE : JV_VIOL;
            end
            SP_XFER, SP_WAIT: begin
                if (is_okay) begin
                    verdict_o = ready_i ? JV_DONE : JV_STRETCH;
                end else if (is_error && !ready_i) begin
                    verdict_o = JV_ERR_FIRST;
                end else begin
                    verdict_o = JV_VIOL;
                end
            end
            SP_ERRRSP: begin
                verdict_o = (ready_i && is_error) ? JV_DONE : JV_VIOL;
            end
            default: begin
                verdict_o = JV_VIOL;
            end
        endcase
    end

endmodule

// File: rtl/ahb_mon_addr_class.sv
module ahb_mon_addr_class
    import ahb_mon_pkg::*;
(
    input  logic                    sel_i,
    input  logic [TRANS_W-1:0]      trans_i,
    output spec_state_e             next_o
);

    always_comb begin
        if (!sel_i) begin
            next_o = SP_ORIG;
        end else begin
            unique case (trans_i)
                HT_IDLE, HT_BUSY:  next_o = SP_IDLEBUSY;
                HT_NONSEQ, HT_SEQ: next_o = SP_XFER;
                default:           next_o = SP_IDLEBUSY;
            endcase
        end
    end

endmodule

// File: rtl/ahb_resp_monitor.sv
module ahb_resp_monitor
    import ahb_mon_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_i,
    input  logic [1:0]              trans_i,
    input  logic                    ready_i,
    input  logic [1:0]              resp_i,
    output logic [2:0]              state_o,
    output logic                    fault_sticky_o,
    output logic                    fault_pulse_o
);

    mon_regs_t   r_d;
    mon_regs_t   r_q;
    verdict_e    verdict;
    spec_state_e addr_next;

    ahb_mon_phase_judge u_judge (
        .st_i      (r_q.st),
        .ready_i   (ready_i),
        .resp_i    (resp_i),
        .verdict_o (verdict)
    );

    ahb_mon_addr_class u_addr (
        .sel_i   (sel_i),
        .trans_i (trans_i),
        .next_o  (addr_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (r_q.st != SP_FAULT) begin
            unique case (verdict)
                JV_NONE, JV_DONE: r_d.st = addr_next;
                JV_STRETCH:       r_d.st = SP_WAIT;
                JV_ERR_FIRST:     r_d.st = SP_ERRRSP;
                default:          r_d.st = SP_FAULT;
            endcase
            if (r_d.st == SP_FAULT) begin
                r_d.sticky = 1'b1;
                r_d.pulse  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= SP_ORIG;
            r_q.sticky <= 1'b0;
            r_q.pulse  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o        = r_q.st;
    assign fault_sticky_o = r_q.sticky;
    assign fault_pulse_o  = r_q.pulse;

    assert_idlebusy_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SP_IDLEBUSY && !ready_i) |=> (r_q.st == SP_FAULT));

    assert_wait_exit_okay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == SP_WAIT) && ready_i && (resp_i == RSP_ERROR)) |=> (r_q.st == SP_FAULT));

    assert_err_second_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == SP_ERRRSP) && !ready_i) |=> (r_q.st == SP_FAULT));

    assert_fault_absorbs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SP_FAULT) |=> (r_q.st == SP_FAULT));

    assert_sticky_tracks_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sticky_o == (state_o == 3'd5));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse_o |=> !fault_pulse_o);

    assert_pulse_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_sticky_o) |-> fault_pulse_o);

    assert_orig_ignores_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SP_ORIG) |=> (r_q.st != SP_FAULT));

endmodule

// File: tb/sim_ahb_resp_monitor.sv
`timescale 1ns/1ps
module sim_ahb_resp_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic [1:0] trans = 2'b00;
    logic       ready = 1'b1;
    logic [1:0] resp = 2'b00;
    logic [2:0] state;
    logic       sticky;
    logic       pulse;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int m_state = 0;
    bit m_sticky = 0;
    bit m_pulse = 0;

    always #2.5 clk = ~clk;

    ahb_resp_monitor u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_i          (sel),
        .trans_i        (trans),
        .ready_i        (ready),
        .resp_i         (resp),
        .state_o        (state),
        .fault_sticky_o (sticky),
        .fault_pulse_o  (pulse)
    );

    // Reference: which state follows, given the rules of the requirements
    function automatic int ref_next(int cur, bit s, bit [1:0] t, bit r, bit [1:0] p);
        bit take_addr;
        take_addr = 0;
        if (cur == 5) return 5;
        case (cur)
            0: take_addr = 1;
            1: if (r && p == 2'b00) take_addr = 1; else return 5;
            2, 3: begin
                if (p == 2'b00 && !r) return 3;
                if (p == 2'b00) take_addr = 1;
                else if (p == 2'b01 && !r) return 4;
                else return 5;
            end
            4: if (r && p == 2'b01) take_addr = 1; else return 5;
            default: return 5;
        endcase
        if (!s) return 0;
        return t[1] ? 2 : 1;
    endfunction

    task automatic compare(string tag);
        vectors++;
        if (state !== m_state[2:0] || sticky !== m_sticky || pulse !== m_pulse) begin
            miscompares++;
            $display("FAIL %s: state/sticky/pulse actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, state, sticky, pulse, m_state, m_sticky, m_pulse);
        end
    endtask

    // drive on falling edge, one rising edge, compare on next falling edge
    task automatic step(bit s, bit [1:0] t, bit r, bit [1:0] p, string tag);
        int nxt;
        sel = s; trans = t; ready = r; resp = p;
        nxt = ref_next(m_state, s, t, r, p);
        m_pulse  = (nxt == 5 && m_state != 5);
        if (nxt == 5) m_sticky = 1;
        m_state = nxt;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(string tag);
        rst_n = 1'b0;
        sel = 0; trans = 2'b00; ready = 1; resp = 2'b00;
        repeat (2) @(negedge clk);
        m_state = 0; m_sticky = 0; m_pulse = 0;
        compare(tag);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R1 reset");
        // first cycle after reset: still idle values
        step(0, 2'b00, 1, 2'b00, "R1 after reset");
        // R11: junk response while unselected
        step(0, 2'b00, 0, 2'b01, "R11 orig ignores resp");
        step(0, 2'b11, 0, 2'b11, "R11 orig ignores resp2");
        // R2 classification
        step(1, 2'b10, 1, 2'b00, "R2 nonseq");
        step(1, 2'b11, 0, 2'b00, "R4 wait");
        step(0, 2'b00, 0, 2'b00, "R12 addr ignored in wait");
        step(1, 2'b00, 0, 2'b00, "R4 wait holds");
        step(1, 2'b01, 1, 2'b00, "R2 busy after wait");
        step(1, 2'b00, 1, 2'b00, "R2 idle");
        step(0, 2'b10, 1, 2'b00, "R2 deselect");
        // R3: idle/busy must be zero-wait
        step(1, 2'b01, 1, 2'b00, "R2 busy");
        step(1, 2'b01, 0, 2'b00, "R3 busy with wait");
        step(1, 2'b10, 1, 2'b00, "R8 fault holds");
        step(0, 2'b00, 1, 2'b00, "R9 pulse gone");
        do_reset("R1 reset 2");
        // legal two-cycle error
        step(1, 2'b10, 1, 2'b00, "R2 nonseq b");
        step(1, 2'b00, 0, 2'b01, "R6 first error");
        step(1, 2'b10, 1, 2'b01, "R7 second error");
        step(1, 2'b00, 1, 2'b00, "R2 after error");
        step(1, 2'b00, 1, 2'b00, "R2 idle again");
        // R7 violation
        step(1, 2'b10, 1, 2'b00, "R2 nonseq c");
        step(1, 2'b00, 0, 2'b01, "R6 first error b");
        step(1, 2'b00, 0, 2'b01, "R7 error not completed");
        do_reset("R1 reset 3");
        // R5 single-cycle error from active phase
        step(1, 2'b10, 1, 2'b00, "R2 nonseq d");
        step(1, 2'b00, 1, 2'b01, "R5 one-cycle error");
        do_reset("R1 reset 4");
        // R5 leaving wait with error
        step(1, 2'b11, 1, 2'b00, "R2 seq");
        step(1, 2'b11, 0, 2'b00, "R4 wait b");
        step(1, 2'b11, 1, 2'b01, "R5 wait exit error");
        do_reset("R1 reset 5");
        // R10 split/retry code
        step(1, 2'b10, 1, 2'b00, "R2 nonseq e");
        step(1, 2'b10, 0, 2'b10, "R10 retry code");
        do_reset("R1 reset 6");
        step(1, 2'b00, 1, 2'b00, "R2 idle b");
        step(1, 2'b00, 1, 2'b11, "R10 split in idle");
        do_reset("R1 reset 7");
        step(1, 2'b00, 1, 2'b00, "R2 idle c");
        step(1, 2'b00, 1, 2'b01, "R3 idle error resp");
        do_reset("R1 reset 8");
        // mixed stimulus, mostly legal
        for (int i = 0; i < 4000; i++) begin
            bit s; bit [1:0] t; bit r; bit [1:0] p; int k;
            s = ($urandom_range(0, 9) != 0);
            t = 2'($urandom_range(0, 3));
            r = ($urandom_range(0, 3) != 0);
            k = $urandom_range(0, 99);
            p = (k < 88) ? 2'b00 : (k < 97) ? 2'b01 : 2'($urandom_range(2, 3));
            if (m_state == 4 && $urandom_range(0, 3) != 0) begin r = 1; p = 2'b01; end
            if ((m_state == 2 || m_state == 3) && p == 2'b01) r = ($urandom_range(0, 7) == 0);
            step(s, t, r, p, "R2..R10 mixed");
            if (m_state == 5 && $urandom_range(0, 3) == 0) do_reset("R1 mixed reset");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule